// File: doc/BRIEF.md
# Receive Window Timing Scheduler

After each uplink, a low-power end node must open its receiver for a short slot that reliably overlaps the downlink preamble. The downlink begins a fixed nominal delay after the uplink completes. The scheduler takes the modulation settings that are active when the uplink completes and the local timing-error budget. From these it derives three values: the symbol duration, a receive window long enough to absorb the clock error, and a signed start offset relative to the nominal downlink start. A microsecond counter then raises `rx_on` at the computed instant.

The window is sized so that at least five preamble symbols fall inside it at either extreme of the error range. Its length is whole symbols, never fewer than five. The start is centred between the earliest and the latest usable turn-on times, so it can lie before or after the nominal downlink start. For the 50 kbit/s frequency-shift mode, the overlap is a fixed 1.3 ms instead of a symbol count.

If the demodulator reports a detected preamble while the window is open, the receiver stays on until the frame ends. Otherwise it drops back at the end of the window. All pins are plain control and status levels or pulses. No streaming interface exists, so there is no back-pressure. The window length in symbols is also output for the radio's symbol-timeout field.

Top module: `rxw_scheduler`

## Requirements
- R1: On an accepted `tx_done`, `symbol_us` latches the symbol period in µs: 1024·2^(sf−7) for `bw_sel`=0 (125 kHz) and 512·2^(sf−7) for `bw_sel`=1 (250 kHz).
- R2: `win_symbols` latches 2 + ceil(2·`err_us`/symbol period), raised to 5 if smaller, and `win_us` latches `win_symbols` × symbol period.
- R3: `offset_us` (two's complement) latches 4·symbol period − `win_us`/2, which may be negative.
- R4: With `fsk_mode`=1, `win_us` = 1300 + 2·`err_us`, `offset_us` = −`win_us`/2, and `symbol_us` = `win_symbols` = 0, whatever `sf` and `bw_sel` hold.
- R5: With `us_tick` high every cycle, `rx_on` first reads high in the (S+1)-th cycle after the edge that samples `tx_done`, where S = `NOMINAL_US` + `offset_us`.
- R6: Without a preamble, `rx_on` stays high for exactly `win_us` ticks and then falls.
- R7: A `preamble_det` pulse while the window is open keeps `rx_on` high past the window until `frame_end` drops it on the next edge; `preamble_det` outside the window has no effect.
- R8: A `tx_done` while a window is pending or open drops `rx_on` and restarts the schedule from the new settings.
- R9: `cfg_err` is high (combinationally) when `fsk_mode`=0 and `sf` lies outside 7..12, or `bw_sel`=1 with `sf`≠7; a `tx_done` then leaves every output unchanged and starts nothing.
- R10: After reset, `rx_on`, `symbol_us`, `win_symbols`, `win_us` and `offset_us` are zero.
- R11: When `NOMINAL_US` + `offset_us` is negative, the start clamps to zero and `rx_on` rises in the first cycle after the `tx_done` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| fsk_mode | input | 1 | 1 = 50 kbit/s frequency-shift mode, 0 = chirp mode |
| bw_sel | input | 1 | 0 = 125 kHz, 1 = 250 kHz |
| sf | input | SF_W (4) | Spreading factor |
| err_us | input | ERR_W (16) | Worst-case local timing error, µs |
| tx_done | input | 1 | Uplink-finished pulse |
| preamble_det | input | 1 | Demodulator found the preamble |
| frame_end | input | 1 | Demodulator finished the frame |
| rx_on | output | 1 | Receiver enable |
| cfg_err | output | 1 | Current settings are not a legal combination |
| symbol_us | output | TIME_W (32) | Latched symbol period, µs |
| win_symbols | output | SYM_CNT_W (10) | Latched window length in symbols |
| win_us | output | TIME_W (32) | Latched window length, µs |
| offset_us | output | TIME_W (32) | Latched signed start offset, µs |

## Verification
The cycle-level properties run continuously. They check that a new `tx_done` always drops the receiver, that `rx_on` only ever rises out of the waiting phase, and that an open window never outlives its latched length. They also check that a preamble converts the window into a hold, that `frame_end` closes it, and that a rejected configuration leaves the latched results untouched. The arithmetic is covered only by the scenarios. These include rounding exactly on a symbol boundary, the five-symbol floor, negative offsets and clamping to a zero start, and the frequency-shift formula. The scenarios also cover the absolute turn-on instant and open length measured against the uplink end, and a restart part-way through a pending schedule.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [1:0] {
    RXW_IDLE,
    RXW_WAIT,
    RXW_OPEN,
    RXW_HOLD
  } rxw_state_e;
endpackage

// File: rtl/rxw_calc.sv
module rxw_calc #(
  parameter int TIME_W         = 32,
  parameter int ERR_W          = 16,
  parameter int SF_W           = 4,
  parameter int SYM_CNT_W      = 10,
  parameter int NOMINAL_US     = 1000000,
  parameter int FSK_OVERLAP_US = 1300,
  parameter int PREAMBLE_SYMS  = 8,
  parameter int LOCK_SYMS      = 5,
  parameter int SF_MIN         = 7,
  parameter int SF_MAX         = 12,
  parameter int BASE_SHIFT     = 10
) (
  input  logic                     fsk_mode,
  input  logic                     bw_sel,
  input  logic [SF_W-1:0]          sf,
  input  logic [ERR_W-1:0]         err_us,
  output logic                     cfg_ok,
  output logic [TIME_W-1:0]        sym_us,
  output logic [SYM_CNT_W-1:0]     win_syms,
  output logic [TIME_W-1:0]        win_us,
  output logic signed [TIME_W-1:0] offset_us,
  output logic [TIME_W-1:0]        start_us
);
  localparam int SHIFT_W   = 6;
  localparam int BASE_SYMS = 2 * LOCK_SYMS - PREAMBLE_SYMS;
  localparam int MAX_SYMS  = (1 << SYM_CNT_W) - 1;

  localparam logic [SF_W-1:0]    SF_LO    = SF_W'(SF_MIN);
  localparam logic [SF_W-1:0]    SF_HI    = SF_W'(SF_MAX);
  localparam logic [SHIFT_W-1:0] BASE_SH  = SHIFT_W'(BASE_SHIFT);
  localparam logic [SHIFT_W-1:0] SF_LO_SH = SHIFT_W'(SF_MIN);
  localparam logic [TIME_W-1:0]  BASE_V   = TIME_W'(BASE_SYMS);
  localparam logic [TIME_W-1:0]  MIN_V    = TIME_W'(LOCK_SYMS);
  localparam logic [TIME_W-1:0]  MAX_V    = TIME_W'(MAX_SYMS);
  localparam logic [TIME_W-1:0]  PRE_V    = TIME_W'(PREAMBLE_SYMS);
  localparam logic [TIME_W-1:0]  FSK_V    = TIME_W'(FSK_OVERLAP_US);
  localparam logic [TIME_W-1:0]  NOM_V    = TIME_W'(NOMINAL_US);

  logic                     sf_ok;
  logic [SHIFT_W-1:0]       shift;
  logic [TIME_W-1:0]        err2;
  logic [TIME_W-1:0]        sym_lora;
  logic [TIME_W-1:0]        ceil_q;
  logic [TIME_W-1:0]        raw_syms;
  logic [SYM_CNT_W-1:0]     syms_lora;
  logic [TIME_W-1:0]        win_lora;
  logic [TIME_W-1:0]        diff;
  logic signed [TIME_W-1:0] off_lora;
  logic [TIME_W-1:0]        win_fsk;
  logic signed [TIME_W-1:0] off_fsk;
  logic signed [TIME_W+1:0] start_s;

  always_comb begin
    sf_ok  = (sf >= SF_LO) && (sf <= SF_HI) && (!bw_sel || (sf == SF_LO));
    cfg_ok = fsk_mode || sf_ok;

    // symbol period is a power of two in microseconds, so division is a shift
    shift    = BASE_SH - SHIFT_W'(bw_sel) + SHIFT_W'(sf) - SF_LO_SH;
    err2     = TIME_W'({err_us, 1'b0});
    sym_lora = TIME_W'(1) << shift;
    ceil_q   = (err2 + sym_lora - TIME_W'(1)) >> shift;
    raw_syms = ceil_q + BASE_V;
    if (raw_syms < MIN_V)      syms_lora = SYM_CNT_W'(MIN_V);
    else if (raw_syms > MAX_V) syms_lora = SYM_CNT_W'(MAX_V);
    else                       syms_lora = SYM_CNT_W'(raw_syms);
    win_lora = TIME_W'(syms_lora) << shift;
    diff     = PRE_V * sym_lora - win_lora;
    off_lora = $signed(diff) >>> 1;

    win_fsk = FSK_V + err2;
    off_fsk = -$signed(win_fsk >> 1);

    if (fsk_mode) begin
      sym_us    = '0;
      win_syms  = '0;
      win_us    = win_fsk;
      offset_us = off_fsk;
    end else begin
      sym_us    = sym_lora;
      win_syms  = syms_lora;
      win_us    = win_lora;
      offset_us = off_lora;
    end

    start_s  = $signed({2'b00, NOM_V}) + $signed({{2{offset_us[TIME_W-1]}}, offset_us});
    start_us = start_s[TIME_W+1] ? '0 : start_s[TIME_W-1:0];
  end
endmodule

// File: rtl/rxw_sched.sv
module rxw_sched
  import rxw_pkg::*;
#(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              load,
  input  logic [TIME_W-1:0] start_us,
  input  logic [TIME_W-1:0] win_us,
  input  logic              preamble_det,
  input  logic              frame_end,
  output logic              rx_on
);
  rxw_state_e        state;
  logic [TIME_W-1:0] elapsed;
  logic [TIME_W-1:0] open_cnt;
  logic [TIME_W-1:0] start_q;
  logic [TIME_W-1:0] win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RXW_IDLE;
      elapsed  <= '0;
      open_cnt <= '0;
      start_q  <= '0;
      win_q    <= '0;
    end else if (load) begin
      state    <= RXW_WAIT;
      elapsed  <= '0;
      open_cnt <= '0;
      start_q  <= start_us;
      win_q    <= win_us;
    end else begin
      case (state)
        RXW_WAIT: begin
          if (elapsed == start_q) begin
            state    <= RXW_OPEN;
            open_cnt <= '0;
          end else if (us_tick) begin
            elapsed <= elapsed + TIME_W'(1);
          end
        end
        RXW_OPEN: begin
          if (preamble_det) begin
            state <= RXW_HOLD;
          end else if (us_tick) begin
            if (open_cnt == win_q - TIME_W'(1)) state <= RXW_IDLE;
            else open_cnt <= open_cnt + TIME_W'(1);
          end
        end
        RXW_HOLD: begin
          if (frame_end) state <= RXW_IDLE;
        end
        default: state <= RXW_IDLE;
      endcase
    end
  end

  assign rx_on = (state == RXW_OPEN) || (state == RXW_HOLD);

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !rx_on); // R8
  AST_OPEN_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_on) |-> ($past(state) == RXW_WAIT)); // R5
  AST_OPEN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RXW_OPEN) |-> (open_cnt < win_q)); // R6
  AST_HOLD_ON_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RXW_OPEN && preamble_det && !load) |=> (state == RXW_HOLD)); // R7
  AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RXW_HOLD && frame_end && !load) |=> !rx_on); // R7
endmodule

// File: rtl/rxw_scheduler.sv
module rxw_scheduler #(
  parameter int TIME_W         = 32,
  parameter int ERR_W          = 16,
  parameter int SF_W           = 4,
  parameter int SYM_CNT_W      = 10,
  parameter int NOMINAL_US     = 1000000,
  parameter int FSK_OVERLAP_US = 1300,
  parameter int PREAMBLE_SYMS  = 8,
  parameter int LOCK_SYMS      = 5,
  parameter int SF_MIN         = 7,
  parameter int SF_MAX         = 12,
  parameter int BASE_SHIFT     = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     us_tick,
  input  logic                     fsk_mode,
  input  logic                     bw_sel,
  input  logic [SF_W-1:0]          sf,
  input  logic [ERR_W-1:0]         err_us,
  input  logic                     tx_done,
  input  logic                     preamble_det,
  input  logic                     frame_end,
  output logic                     rx_on,
  output logic                     cfg_err,
  output logic [TIME_W-1:0]        symbol_us,
  output logic [SYM_CNT_W-1:0]     win_symbols,
  output logic [TIME_W-1:0]        win_us,
  output logic signed [TIME_W-1:0] offset_us
);
  localparam logic [SYM_CNT_W-1:0] FLOOR_V = SYM_CNT_W'(LOCK_SYMS);

  logic                     c_ok;
  logic [TIME_W-1:0]        c_sym;
  logic [SYM_CNT_W-1:0]     c_syms;
  logic [TIME_W-1:0]        c_win;
  logic signed [TIME_W-1:0] c_off;
  logic [TIME_W-1:0]        c_start;
  logic                     accept;

  rxw_calc #(
    .TIME_W(TIME_W), .ERR_W(ERR_W), .SF_W(SF_W), .SYM_CNT_W(SYM_CNT_W),
    .NOMINAL_US(NOMINAL_US), .FSK_OVERLAP_US(FSK_OVERLAP_US),
    .PREAMBLE_SYMS(PREAMBLE_SYMS), .LOCK_SYMS(LOCK_SYMS),
    .SF_MIN(SF_MIN), .SF_MAX(SF_MAX), .BASE_SHIFT(BASE_SHIFT)
  ) u_calc (
    .fsk_mode (fsk_mode),
    .bw_sel   (bw_sel),
    .sf       (sf),
    .err_us   (err_us),
    .cfg_ok   (c_ok),
    .sym_us   (c_sym),
    .win_syms (c_syms),
    .win_us   (c_win),
    .offset_us(c_off),
    .start_us (c_start)
  );

  assign accept  = tx_done && c_ok;
  assign cfg_err = !c_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      symbol_us   <= '0;
      win_symbols <= '0;
      win_us      <= '0;
      offset_us   <= '0;
    end else if (accept) begin
      symbol_us   <= c_sym;
      win_symbols <= c_syms;
      win_us      <= c_win;
      offset_us   <= c_off;
    end
  end

  rxw_sched #(.TIME_W(TIME_W)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .us_tick     (us_tick),
    .load        (accept),
    .start_us    (c_start),
    .win_us      (c_win),
    .preamble_det(preamble_det),
    .frame_end   (frame_end),
    .rx_on       (rx_on)
  );

  AST_WINDOW_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (win_symbols != '0) |-> (win_symbols >= FLOOR_V)); // R2
  AST_BAD_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && cfg_err) |=> ($stable(win_us) && $stable(offset_us) && $stable(win_symbols))); // R9
endmodule

// File: tb/sim_rxw_scheduler.sv
module sim_rxw_scheduler;
  localparam int CLK_PERIOD = 10;
  localparam int NOM        = 8000;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               us_tick;
  logic               fsk_mode;
  logic               bw_sel;
  logic [3:0]         sf;
  logic [15:0]        err_us;
  logic               tx_done;
  logic               preamble_det;
  logic               frame_end;
  logic               rx_on;
  logic               cfg_err;
  logic [31:0]        symbol_us;
  logic [9:0]         win_symbols;
  logic [31:0]        win_us;
  logic signed [31:0] offset_us;

  rxw_scheduler #(.NOMINAL_US(NOM)) u0 (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .fsk_mode(fsk_mode),
    .bw_sel(bw_sel), .sf(sf), .err_us(err_us), .tx_done(tx_done),
    .preamble_det(preamble_det), .frame_end(frame_end), .rx_on(rx_on),
    .cfg_err(cfg_err), .symbol_us(symbol_us), .win_symbols(win_symbols),
    .win_us(win_us), .offset_us(offset_us)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int rise;
    int len;
  } exp_t;

  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input bit fsk, input bit bw, input int sfv, input int err,
                                output longint sym, output longint syms, output longint win,
                                output longint off, output longint start);
    if (fsk) begin
      sym  = 0;
      syms = 0;
      win  = 1300 + 2 * err;
      off  = -(win / 2);
    end else begin
      sym  = (bw ? 512 : 1024) * (longint'(1) << (sfv - 7));
      syms = 2 + (2 * err + sym - 1) / sym;
      if (syms < 5) syms = 5;
      win  = syms * sym;
      off  = 4 * sym - win / 2;
    end
    start = NOM + off;
    if (start < 0) start = 0;
  endfunction

  // driver: applies a tx_done, queues the expected window, checks latched results
  task automatic run_tx(input bit fsk, input bit bw, input int sfv, input int err,
                        input bit expect_win, input bit check_len);
    longint sym, syms, win, off, start;
    exp_t item;
    @(negedge clk);
    fsk_mode = fsk;
    bw_sel   = bw;
    sf       = 4'(sfv);
    err_us   = 16'(err);
    tx_done  = 1'b1;
    model(fsk, bw, sfv, err, sym, syms, win, off, start);
    if (expect_win) begin
      item.rise = int'(start) + 1;
      item.len  = check_len ? int'(win) : 0;
      sb_q.push_back(item);
    end
    @(negedge clk);
    tx_done = 1'b0;
    chk(fsk ? "R4" : "R1", "symbol_us", longint'(symbol_us), sym);
    chk(fsk ? "R4" : "R2", "win_symbols", longint'(win_symbols), syms);
    chk(fsk ? "R4" : "R2", "win_us", longint'(win_us), win);
    chk(fsk ? "R4" : "R3", "offset_us", longint'(offset_us), off);
  endtask

  task automatic pulse_preamble();
    @(negedge clk);
    preamble_det = 1'b1;
    @(negedge clk);
    preamble_det = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  // monitor: measures turn-on delay and open length, compares with the queue
  initial begin
    int   cnt = 0;
    int   len = 0;
    bit   prev = 1'b0;
    exp_t cur;
    cur.rise = 0;
    cur.len  = 0;
    forever begin
      @(posedge clk);
      #1;
      if (!rst_n) begin
        prev = 1'b0;
      end else begin
        if (tx_done) cnt = 0;
        else cnt++;
        if (rx_on && !prev) begin
          if (sb_q.size() == 0) begin
            chk("R9", "unexpected receive window", 1, 0);
            cur.len = 0;
          end else begin
            cur = sb_q.pop_front();
            chk("R5", "turn-on delay", cnt, cur.rise);
          end
          len = 1;
        end else if (rx_on) begin
          len++;
        end else if (prev && cur.len != 0) begin
          chk("R6", "open length", len, cur.len);
        end
        prev = rx_on;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n        = 1'b0;
    us_tick      = 1'b1;
    fsk_mode     = 1'b0;
    bw_sel       = 1'b0;
    sf           = 4'd7;
    err_us       = '0;
    tx_done      = 1'b0;
    preamble_det = 1'b0;
    frame_end    = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "rx_on after reset", longint'(rx_on), 0);
    chk("R10", "symbol_us after reset", longint'(symbol_us), 0);
    chk("R10", "win_symbols after reset", longint'(win_symbols), 0);
    chk("R10", "win_us after reset", longint'(win_us), 0);
    chk("R10", "offset_us after reset", longint'(offset_us), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // positive offset, floor reached through rounding, full window
    run_tx(1'b0, 1'b0, 7, 1500, 1'b1, 1'b1);
    repeat (9536 + 5120 + 20) @(negedge clk);

    // 250 kHz, error on an exact symbol boundary; stray preamble while waiting
    run_tx(1'b0, 1'b1, 7, 768, 1'b1, 1'b1);
    repeat (200) @(negedge clk);
    pulse_preamble();
    chk("R7", "rx_on after early preamble", longint'(rx_on), 0);
    repeat (8768 + 2560) @(negedge clk);
    chk("R7", "window closed despite early preamble", longint'(rx_on), 0);

    // negative offset, 12-symbol window
    run_tx(1'b0, 1'b0, 7, 5000, 1'b1, 1'b1);
    repeat (5952 + 12288 + 20) @(negedge clk);

    // zero error gives the floor; preamble holds the receiver
    run_tx(1'b0, 1'b0, 8, 0, 1'b1, 1'b0);
    repeat (11072 + 100) @(negedge clk);
    chk("R5", "rx_on inside window", longint'(rx_on), 1);
    pulse_preamble();
    repeat (10240 + 50) @(negedge clk);
    chk("R7", "rx_on held past window", longint'(rx_on), 1);
    pulse_end();
    chk("R7", "rx_on after frame_end", longint'(rx_on), 0);

    // frequency-shift mode
    run_tx(1'b1, 1'b0, 0, 100, 1'b1, 1'b1);
    repeat (7250 + 1500 + 20) @(negedge clk);

    // start clamps to zero
    run_tx(1'b0, 1'b0, 7, 30000, 1'b1, 1'b0);
    chk("R11", "rx_on right after tx edge", longint'(rx_on), 0);
    @(negedge clk);
    chk("R11", "rx_on one tick later", longint'(rx_on), 1);
    pulse_preamble();
    repeat (5) @(negedge clk);
    pulse_end();
    chk("R7", "rx_on after frame_end", longint'(rx_on), 0);

    // arithmetic at larger spreading factors (schedules are overridden below)
    run_tx(1'b0, 1'b0, 12, 1500, 1'b0, 1'b0);
    run_tx(1'b0, 1'b0, 10, 20000, 1'b0, 1'b0);

    // restart while pending (R8)
    run_tx(1'b0, 1'b0, 7, 1500, 1'b0, 1'b0);
    repeat (1000) @(negedge clk);
    chk("R8", "rx_on while pending", longint'(rx_on), 0);
    run_tx(1'b1, 1'b0, 0, 100, 1'b1, 1'b1);
    repeat (7250 + 1500 + 20) @(negedge clk);
    chk("R8", "rx_on after restarted window", longint'(rx_on), 0);

    // illegal settings
    @(negedge clk);
    fsk_mode = 1'b0;
    bw_sel   = 1'b1;
    sf       = 4'd11;
    err_us   = 16'd10;
    #1;
    chk("R9", "cfg_err for sf11 at 250k", longint'(cfg_err), 1);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    @(negedge clk);
    chk("R9", "win_us kept", longint'(win_us), 1500);
    chk("R9", "offset_us kept", longint'(offset_us), -750);
    chk("R9", "win_symbols kept", longint'(win_symbols), 0);
    repeat (9000) @(negedge clk);
    chk("R9", "no window after rejected tx_done", longint'(rx_on), 0);
    bw_sel = 1'b0;
    sf     = 4'd6;
    #1;
    chk("R9", "cfg_err for sf6", longint'(cfg_err), 1);
    sf = 4'd12;
    #1;
    chk("R9", "cfg_err for sf12 at 125k", longint'(cfg_err), 0);

    repeat (5) @(negedge clk);
    chk("R6", "windows left unmatched", longint'(sb_q.size()), 0);
    finish_run();
  end
endmodule